// File: doc/BRIEF.md
# Addressed Backplane Readout Port

This block lets a master on a shared backplane pull result words out of a board-local output queue. The master places a five-bit address on the bus and raises a strobe. The board compares the upper three address bits with its own three-bit jumper identity. On a match, the board takes the next 16-bit word from the head of its queue and drives it toward the shared data lines. If the address does not match, the board leaves the lines released. The two lowest address bits play no part, so every channel sub-address of a board reaches the same queue. Up to eight boards, each with a distinct identity, can therefore share one bus.

On the local side, a producer hands in results. A narrow result becomes one queue word. A wide 32-bit result becomes two words, with the low half queued first. A half-full indication tells the producer when the queue needs topping up. A strobe that selects the board while the queue is empty returns zero and raises a sticky underflow indication.

Top module: `bp_readout_port`

## Requirements
- R1: A strobe selects the board only when `bp_addr[4:2]` equals `board_id`, with `board_id[0]` compared against `bp_addr[2]`.
- R2: `bp_addr[1:0]` have no effect on selection. All four sub-addresses of a board read the same queue.
- R3: `bp_oe` rises in the cycle after a clock edge at which the strobe first goes high with a matching address. It stays high while the strobe remains high and the address keeps matching. It is low in every other cycle, including after a rising edge with a non-matching address.
- R4: Each strobe assertion removes exactly one word, at its leading edge. Holding the strobe high removes nothing further, and a strobe that does not match removes nothing.
- R5: Words leave in arrival order. A result pushed with `res_wide`=1 enqueues `res_data[15:0]` and then `res_data[31:16]`. A result pushed with `res_wide`=0 enqueues only `res_data[15:0]`.
- R6: `half_full` is high exactly when the queue holds at least DEPTH/2 words (8 by default).
- R7: A selecting strobe on an empty queue puts 0 on `bp_data` and sets `underflow`, which stays high until reset.
- R8: A push whose word count exceeds the free space at that clock edge is discarded in full. No half of a wide result is stored alone.
- R9: After reset, `bp_oe`, `half_full` and `underflow` are low and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| board_id | input | 3 | Jumpered board identity |
| bp_addr | input | 5 | Backplane address |
| bp_strobe | input | 1 | Address-valid strobe from the master |
| res_valid | input | 1 | Producer push request |
| res_wide | input | 1 | 1: push two words (low half first); 0: push one |
| res_data | input | 32 | Producer result |
| bp_data | output | 16 | Word for the shared data lines |
| bp_oe | output | 1 | Drive enable for the data lines (released when low) |
| half_full | output | 1 | Queue holds at least DEPTH/2 words |
| underflow | output | 1 | Sticky: a read found the queue empty |

## Verification
Selection is tried with addresses that match in the upper bits under each of the four low-bit values. It is also tried with addresses that differ from the identity in only one upper bit, which shows that the upper bits are compared bit by bit and that the low bits are ignored. After each non-matching strobe, a matching read returns the word that was waiting, which shows that the non-matching strobe removed nothing. A held strobe followed by a second read separates one pop per leading edge from one pop per cycle. Wide and narrow pushes, a push into a nearly full queue, and reads past empty cover word order, whole-push discard and underflow.

// File: rtl/bpr_pkg.sv
// Shared widths and helpers for the backplane readout port.
// Assumes a 5-bit backplane address whose top three bits carry the board identity.
package bpr_pkg;
    localparam int ADDR_W  = 5;
    localparam int ID_W    = 3;
    localparam int WORD_W  = 16;
    localparam int RES_W   = 2 * WORD_W;

    // Board-select field of a backplane address (low sub-address bits dropped).
    function automatic logic [ID_W-1:0] sel_field(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: ID_W];
    endfunction
endpackage

// File: rtl/bpr_select.sv
// Strobe qualification: detects the strobe's leading edge and decides
// whether this board is addressed. Assumes the strobe is already synchronous to clk.
module bpr_select
    import bpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   board_id,
    input  logic [ADDR_W-1:0] bp_addr,
    input  logic              bp_strobe,
    output logic              hit_now,    // strobe high and address matches
    output logic              hit_rise    // leading edge of a matching strobe
);
    logic strobe_q;

    // Remember last strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= bp_strobe;
    end

    // Compare only the identity field; the sub-address bits never enter.
    always_comb begin
        hit_now  = bp_strobe && (sel_field(bp_addr) == board_id);
        hit_rise = hit_now && !strobe_q;
    end

    AST_ONE_POP_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rise |=> !hit_rise); // R4
endmodule

// File: rtl/bpr_fifo.sv
// Output queue with a one-or-two-word write port and a single-word read port.
// Assumes DEPTH is a power of two >= 4; a push that does not fit is dropped whole.
module bpr_fifo #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_two,
    input  logic [WORD_W-1:0] wr_lo,
    input  logic [WORD_W-1:0] wr_hi,
    input  logic              rd_en,
    output logic [WORD_W-1:0] head,
    output logic              empty,
    output logic              half_full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(DEPTH / 2);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [CNT_W-1:0]  count, n_wr, n_acc;
    logic              wr_ok, rd_ok;

    // Decide how many words enter and whether a read is honoured.
    always_comb begin
        n_wr  = wr_two ? CNT_W'(2) : CNT_W'(1);
        wr_ok = wr_en && (n_wr <= (DEPTH_C - count));
        n_acc = wr_ok ? n_wr : '0;
        rd_ok = rd_en && (count != '0);
        empty = (count == '0);
        half_full = (count >= HALF_C);
        head  = mem[rp];
    end

    // Store accepted words, low half first.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wp] <= wr_lo;
            if (wr_two) mem[wp + PTR_W'(1)] <= wr_hi;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            wp    <= wp + PTR_W'(n_acc);
            rp    <= rp + (rd_ok ? PTR_W'(1) : PTR_W'(0));
            count <= count + n_acc - (rd_ok ? CNT_W'(1) : CNT_W'(0));
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C); // R8
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !empty && !wr_en) |=> (count == $past(count) - CNT_W'(1))); // R4
endmodule

// File: rtl/bpr_drive.sv
// Output stage: latches the popped word (or zero on empty) and holds the
// drive enable for the duration of a strobe that began with a match.
module bpr_drive #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_now,
    input  logic              hit_rise,
    input  logic              q_empty,
    input  logic [WORD_W-1:0] q_head,
    output logic [WORD_W-1:0] bus_word,
    output logic              bus_oe,
    output logic              uflow
);
    // Capture the head word at the leading edge of a matching strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_word <= '0;
        else if (hit_rise) bus_word <= q_empty ? '0 : q_head;
    end

    // Drive only for a strobe whose leading edge matched, while it still matches.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_oe <= 1'b0;
        else        bus_oe <= hit_rise || (bus_oe && hit_now);
    end

    // Sticky underflow on any read of an empty queue.
    always_ff @(posedge clk) begin
        if (!rst_n)                    uflow <= 1'b0;
        else if (hit_rise && q_empty)  uflow <= 1'b1;
    end

    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> uflow); // R7
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_rise && q_empty) |=> (bus_word == '0)); // R7
    AST_OE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(hit_now)); // R3
endmodule

// File: rtl/bp_readout_port.sv
// Top of the addressed backplane readout port: select logic, output queue and
// bus drive stage. The pad-level tristate is formed outside from bp_data/bp_oe.
module bp_readout_port
    import bpr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   board_id,
    input  logic [ADDR_W-1:0] bp_addr,
    input  logic              bp_strobe,
    input  logic              res_valid,
    input  logic              res_wide,
    input  logic [RES_W-1:0]  res_data,
    output logic [WORD_W-1:0] bp_data,
    output logic              bp_oe,
    output logic              half_full,
    output logic              underflow
);
    logic              hit_now, hit_rise, q_empty;
    logic [WORD_W-1:0] q_head;

    bpr_select u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .board_id (board_id),
        .bp_addr  (bp_addr),
        .bp_strobe(bp_strobe),
        .hit_now  (hit_now),
        .hit_rise (hit_rise)
    );

    bpr_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (res_valid),
        .wr_two   (res_wide),
        .wr_lo    (res_data[WORD_W-1:0]),
        .wr_hi    (res_data[RES_W-1:WORD_W]),
        .rd_en    (hit_rise),
        .head     (q_head),
        .empty    (q_empty),
        .half_full(half_full)
    );

    bpr_drive #(.WORD_W(WORD_W)) u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_now  (hit_now),
        .hit_rise (hit_rise),
        .q_empty  (q_empty),
        .q_head   (q_head),
        .bus_word (bp_data),
        .bus_oe   (bp_oe),
        .uflow    (underflow)
    );

    AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bp_strobe)) |-> !bp_oe); // R3
endmodule

// File: tb/bp_readout_port_bench.sv
module bp_readout_port_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  board_id;
    logic [4:0]  bp_addr;
    logic        bp_strobe;
    logic        res_valid, res_wide;
    logic [31:0] res_data;
    logic [15:0] bp_data;
    logic        bp_oe, half_full, underflow;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bp_readout_port u_bp_readout_port (
        .clk(clk), .rst_n(rst_n), .board_id(board_id), .bp_addr(bp_addr),
        .bp_strobe(bp_strobe), .res_valid(res_valid), .res_wide(res_wide),
        .res_data(res_data), .bp_data(bp_data), .bp_oe(bp_oe),
        .half_full(half_full), .underflow(underflow)
    );

    // {address[4:0], expect_select}; board identity is 3'b101
    localparam logic [5:0] VEC [8] = '{
        {5'b10100, 1'b1}, {5'b10101, 1'b1}, {5'b10110, 1'b1}, {5'b10111, 1'b1},
        {5'b00100, 1'b0}, {5'b11100, 1'b0}, {5'b10000, 1'b0}, {5'b01101, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic wide, input logic [31:0] d);
        @(negedge clk);
        res_valid = 1'b1; res_wide = wide; res_data = d;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    // Strobe for 'hold' cycles, return oe and data seen after the first edge.
    task automatic bus_read(input logic [4:0] a, input int hold,
                            output logic oe, output logic [15:0] d);
        @(negedge clk);
        bp_addr = a; bp_strobe = 1'b1;
        @(negedge clk);
        oe = bp_oe; d = bp_data;
        for (int k = 1; k < hold; k++) @(negedge clk);
        bp_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic        oe;
        logic [15:0] d;
        board_id = 3'b101; bp_addr = '0; bp_strobe = 0;
        res_valid = 0; res_wide = 0; res_data = '0; rst_n = 0;
        do_reset();

        // R9 reset state
        check("R9 oe", bp_oe, 0);
        check("R9 half_full", half_full, 0);
        check("R9 underflow", underflow, 0);

        // Table walk: R1 / R2 selection and release
        for (int i = 0; i < 8; i++) begin
            logic [15:0] w;
            w = 16'hA000 + 16'(i);
            push(1'b0, {16'h0, w});
            bus_read(VEC[i][5:1], 1, oe, d);
            check(VEC[i][0] ? "R2 select" : "R1 no select", oe, VEC[i][0]);
            if (VEC[i][0]) check("R1 data", d, w);
            else begin
                check("R3 released after miss", bp_oe, 0);
                bus_read(5'b10100, 1, oe, d);
                check("R4 miss did not pop", d, w);
            end
        end

        // R3 / R4: held strobe pops one word only
        push(1'b0, 32'h1111);
        push(1'b0, 32'h2222);
        bus_read(5'b10110, 3, oe, d);
        check("R3 oe during held strobe", oe, 1);
        check("R4 first word", d, 16'h1111);
        check("R3 oe low after strobe", bp_oe, 0);
        bus_read(5'b10111, 1, oe, d);
        check("R4 second word after hold", d, 16'h2222);

        // R5 wide result low half first, then narrow
        push(1'b1, 32'hBEEF_CAFE);
        push(1'b0, 32'h5555_0123);
        bus_read(5'b10100, 1, oe, d); check("R5 low half first", d, 16'hCAFE);
        bus_read(5'b10100, 1, oe, d); check("R5 high half second", d, 16'hBEEF);
        bus_read(5'b10100, 1, oe, d); check("R5 narrow word", d, 16'h0123);

        // R6 half-full threshold at 8 words
        for (int i = 0; i < 7; i++) push(1'b0, 32'h300 + 32'(i));
        check("R6 seven words", half_full, 0);
        push(1'b0, 32'h307);
        check("R6 eight words", half_full, 1);
        bus_read(5'b10100, 1, oe, d);
        check("R6 back to seven", half_full, 0);

        // R8 fill to 15, a wide push must be dropped whole
        for (int i = 0; i < 8; i++) push(1'b0, 32'h400 + 32'(i));
        push(1'b1, 32'hDEAD_BEEF);
        for (int i = 0; i < 15; i++) bus_read(5'b10100, 1, oe, d);
        check("R8 last stored word", d, 16'h0407);
        check("R7 not yet underflow", underflow, 0);
        bus_read(5'b10100, 1, oe, d);
        check("R8 wide push discarded, R7 empty reads zero", d, 16'h0000);
        check("R7 underflow set", underflow, 1);
        push(1'b0, 32'h0777);
        bus_read(5'b10100, 1, oe, d);
        check("R7 underflow sticky", underflow, 1);
        check("R7 normal read after underflow", d, 16'h0777);

        // R9 reset clears sticky flag and empties queue
        push(1'b0, 32'h0999);
        do_reset();
        check("R9 underflow cleared", underflow, 0);
        bus_read(5'b10100, 1, oe, d);
        check("R9 queue empty after reset", d, 16'h0000);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule